// File: doc/BRIEF.md
# Bus-Master DMA Command Register

This block holds the 16-bit command word of one IDE-style bus-master DMA channel. A host programs it through a small synchronous register port. The block turns the host's writes into a start level and a transfer direction for the transfer engine that sits beside it. It also tracks whether a transfer is running or has finished.

Software sets the start bit to launch a transfer. The direction bit freezes while that transfer runs. Clearing start ends the transfer and throws away all of its state, so a later start always begins from scratch. If software clears start before the engine has reported completion, the block sends the engine a one-cycle abort. When the aborted transfer was moving data from the device into memory, it also sends a one-cycle drop, so the engine discards inbound data it has not yet written. Two first-party DMA flags supplied by the engine appear in the register image as read-only bits.

Top module: `bm_cmd_unit`

## Requirements
- R1: After reset, the register reads 0x0000 (with both first-party inputs low) and eng_start, eng_wr_mem, st_active, st_done, eng_abort and eng_drop are all 0.
- R2: A write updates the register only when reg_addr equals 0x08 and reg_be[0] is 1. Bit 0 is start, and eng_start follows it from the clock edge of the write. Writes to any other address, and writes with reg_be[0]=0, change nothing.
- R3: Bit 3 is the direction (0 = engine reads memory, 1 = engine writes memory). When no transfer is active, a write loads it and eng_wr_mem follows it.
- R4: While st_active is 1, writes to bit 3 are ignored. Once the transfer completes or is aborted, bit 3 can be written again.
- R5: A write that takes start from 0 to 1 sets st_active and clears st_done. An eng_done pulse while active sets st_done and clears st_active. st_done and st_active are never 1 together.
- R6: A write that clears start while st_active=1 and st_done=0 makes eng_abort high for exactly the one cycle after the write edge. The same edge clears st_active.
- R7: Clearing start after completion, or writing 0 to start when it is already 0, produces no abort.
- R8: eng_drop pulses in the same cycle as eng_abort only when direction bit 3 is 1. Otherwise it stays 0.
- R9: Bit 9 reads fp_dir and bit 8 reads fp_act. Writes do not affect either bit.
- R10: Bits 15:10, 7:4 and 2:1 always read 0. Reads have no side effects. Reads from an address other than 0x08 return 0.
- R11: Writing start=1 after an abort or a completion begins a fresh transfer: st_active=1 and st_done=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_be | input | 2 | Byte enables (bit 0 = low byte) |
| reg_rdata | output | 16 | Combinational read data |
| eng_done | input | 1 | Completion pulse from the engine |
| fp_dir | input | 1 | First-party DMA direction (1 = host to device) |
| fp_act | input | 1 | First-party DMA active |
| eng_start | output | 1 | Start level to the engine |
| eng_wr_mem | output | 1 | Direction to the engine (1 = writes memory) |
| eng_abort | output | 1 | One-cycle abort pulse |
| eng_drop | output | 1 | One-cycle pulse: discard pending inbound data |
| st_active | output | 1 | Transfer active status |
| st_done | output | 1 | Transfer completed status |

## Verification
The hardest case to reach is an abort with inbound data pending. It needs start set with direction 1, no eng_done pulse yet, and then a write that clears start while keeping bit 3 at 1. The stimulus builds that exact order of writes and checks abort and drop in the one cycle they should be high. It then repeats the sequence with direction 0, and again after a completion, to show that the pulse appears only under the full condition.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned BIT_RUN  = 0;
  localparam int unsigned BIT_DIR  = 3;
  localparam int unsigned BIT_FPA  = 8;
  localparam int unsigned BIT_FPD  = 9;
  localparam logic [REG_W-1:0] RSV_MASK = 16'hFCF6;

  typedef struct packed {
    logic run;
    logic dir;
  } wr_fields_t;

  function automatic logic [REG_W-1:0] build_image(input logic run, input logic dir,
                                                   input logic fpa, input logic fpd);
    logic [REG_W-1:0] v;
    v = '0;
    v[BIT_RUN] = run;
    v[BIT_DIR] = dir;
    v[BIT_FPA] = fpa;
    v[BIT_FPD] = fpd;
    return v;
  endfunction

  function automatic logic abort_needed(input logic run_now, input logic run_new,
                                        input logic active, input logic done);
    return run_now & ~run_new & active & ~done;
  endfunction
endpackage

// File: rtl/cmd_host_dec.sv
module cmd_host_dec
  import bmc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h08
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [1:0]        be,
  output logic              sel,
  output logic              lo_wr,
  output wr_fields_t        fields
);
  assign sel        = (addr == REG_OFS);
  assign lo_wr      = sel & wr & be[0];
  assign fields.run = wdata[BIT_RUN];
  assign fields.dir = wdata[BIT_DIR];
endmodule

// File: rtl/cmd_xfer_track.sv
module cmd_xfer_track
  import bmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lo_wr,
  input  wr_fields_t fields,
  input  logic       eng_done,
  output logic       run_q,
  output logic       dir_q,
  output logic       active_q,
  output logic       done_q,
  output logic       abort_q,
  output logic       drop_q,
  output logic       evt_start_rise,
  output logic       evt_abort,
  output logic       evt_complete
);
  assign evt_start_rise = lo_wr & ~run_q & fields.run;
  assign evt_abort      = lo_wr & abort_needed(run_q, fields.run, active_q, done_q);
  assign evt_complete   = eng_done & active_q & ~evt_abort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      dir_q    <= 1'b0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      abort_q  <= 1'b0;
      drop_q   <= 1'b0;
    end else begin
      abort_q <= evt_abort;
      drop_q  <= evt_abort & dir_q;
      if (lo_wr) begin
        run_q <= fields.run;
        if (!active_q) dir_q <= fields.dir;
      end
      if (evt_start_rise) begin
        active_q <= 1'b1;
        done_q   <= 1'b0;
      end else if (evt_abort) begin
        active_q <= 1'b0;
      end else if (evt_complete) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmd_img.sv
module cmd_img
  import bmc_pkg::*;
(
  input  logic             sel,
  input  logic             run,
  input  logic             dir,
  input  logic             fpa,
  input  logic             fpd,
  output logic [REG_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (sel) rdata = build_image(run, dir, fpa, fpd);
  end
endmodule

// File: rtl/bm_cmd_unit.sv
module bm_cmd_unit
  import bmc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [15:0]       reg_wdata,
  input  logic [1:0]        reg_be,
  output logic [15:0]       reg_rdata,
  input  logic              eng_done,
  input  logic              fp_dir,
  input  logic              fp_act,
  output logic              eng_start,
  output logic              eng_wr_mem,
  output logic              eng_abort,
  output logic              eng_drop,
  output logic              st_active,
  output logic              st_done
);
  logic       sel;
  logic       lo_wr;
  wr_fields_t fields;
  logic       evt_start_rise;
  logic       evt_abort;
  logic       evt_complete;

  cmd_host_dec #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_dec (
    .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata), .be(reg_be),
    .sel(sel), .lo_wr(lo_wr), .fields(fields)
  );

  cmd_xfer_track u_trk (
    .clk(clk), .rst_n(rst_n), .lo_wr(lo_wr), .fields(fields), .eng_done(eng_done),
    .run_q(eng_start), .dir_q(eng_wr_mem), .active_q(st_active), .done_q(st_done),
    .abort_q(eng_abort), .drop_q(eng_drop),
    .evt_start_rise(evt_start_rise), .evt_abort(evt_abort), .evt_complete(evt_complete)
  );

  cmd_img u_img (
    .sel(sel), .run(eng_start), .dir(eng_wr_mem), .fpa(fp_act), .fpd(fp_dir),
    .rdata(reg_rdata)
  );
endmodule

// File: rtl/bm_cmd_chk.sv
module bm_cmd_chk
  import bmc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        sel,
  input logic [15:0] reg_rdata,
  input logic        fp_dir,
  input logic        fp_act,
  input logic        eng_start,
  input logic        eng_wr_mem,
  input logic        eng_abort,
  input logic        eng_drop,
  input logic        st_active,
  input logic        st_done,
  input logic        evt_start_rise,
  input logic        evt_abort
);
  p_abort_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |=> !eng_abort);
  p_abort_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |-> (!st_active && !eng_start));
  p_abort_from_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_abort |-> (eng_start && st_active && !st_done));
  p_dir_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_active |=> $stable(eng_wr_mem));
  p_drop_with_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_drop |-> (eng_abort && eng_wr_mem));
  p_done_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_done && st_active));
  p_fresh_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_start_rise |=> (st_active && !st_done && eng_start));
  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & RSV_MASK) == 16'h0000);
  p_fp_mirror_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel |-> (reg_rdata[BIT_FPD] == fp_dir && reg_rdata[BIT_FPA] == fp_act));
endmodule

bind bm_cmd_unit bm_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .reg_rdata(reg_rdata),
  .fp_dir(fp_dir), .fp_act(fp_act), .eng_start(eng_start), .eng_wr_mem(eng_wr_mem),
  .eng_abort(eng_abort), .eng_drop(eng_drop), .st_active(st_active), .st_done(st_done),
  .evt_start_rise(evt_start_rise), .evt_abort(evt_abort)
);

// File: tb/sim_bm_cmd_unit.sv
module sim_bm_cmd_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = 8'h08;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [1:0]  reg_be = '0;
  logic [15:0] reg_rdata;
  logic        eng_done = 1'b0, fp_dir = 1'b0, fp_act = 1'b0;
  logic        eng_start, eng_wr_mem, eng_abort, eng_drop, st_active, st_done;

  always #10 clk = ~clk;

  bm_cmd_unit u0 (.*);

  typedef struct {
    string       tag;
    logic [21:0] mask;
    logic [21:0] val;
  } item_t;
  item_t q[$];
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  localparam logic [21:0] M_ALL = 22'h3FFFFF;
  localparam logic [21:0] M_RD  = 22'h00FFFF;

  function automatic logic [21:0] pack(input logic ab, input logic dr, input logic dn,
                                       input logic ac, input logic wm, input logic st,
                                       input logic [15:0] rd);
    return {ab, dr, dn, ac, wm, st, rd};
  endfunction

  // monitor: pops expectations shortly after the driver posts them
  initial forever begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [21:0] got;
      it  = q.pop_front();
      got = pack(eng_abort, eng_drop, st_done, st_active, eng_wr_mem, eng_start, reg_rdata);
      checks++;
      if ((got & it.mask) !== (it.val & it.mask)) begin
        failures++;
        $display("FAIL %s got %h exp %h", it.tag, got & it.mask, it.val & it.mask);
      end
    end
  end

  task automatic expect_obs(input string tag, input logic [21:0] mask, input logic [21:0] val);
    q.push_back('{tag, mask, val});
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] be);
    reg_addr = a; reg_wdata = d; reg_be = be; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h08; reg_be = 2'b00;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1: reset image and outputs
    expect_obs("R1 reset", M_ALL, pack(0,0,0,0,0,0,16'h0000));
    step();
    // R10: reserved bits ignore writes
    wr(8'h08, 16'hFFF6, 2'b11);
    expect_obs("R10 reserved", M_ALL, pack(0,0,0,0,0,0,16'h0000));
    step();
    // R2: other address and missing low byte enable
    wr(8'h0C, 16'h0009, 2'b11);
    wr(8'h08, 16'h0009, 2'b10);
    expect_obs("R2 ignored write", M_ALL, pack(0,0,0,0,0,0,16'h0000));
    step();
    // R10: other address reads zero
    reg_addr = 8'h04;
    expect_obs("R10 other addr", M_RD, 22'h0);
    step();
    reg_addr = 8'h08;
    // R3: direction write while idle
    wr(8'h08, 16'h0008, 2'b01);
    expect_obs("R3 dir set", M_ALL, pack(0,0,0,0,1,0,16'h0008));
    step();
    wr(8'h08, 16'h0000, 2'b01);
    expect_obs("R3 dir clear", M_ALL, pack(0,0,0,0,0,0,16'h0000));
    step();
    // R2 R5: start with dir=1
    wr(8'h08, 16'h0009, 2'b01);
    expect_obs("R5 start", M_ALL, pack(0,0,0,1,1,1,16'h0009));
    step();
    // R4: dir locked while active
    wr(8'h08, 16'h0001, 2'b01);
    expect_obs("R4 dir locked", M_ALL, pack(0,0,0,1,1,1,16'h0009));
    step();
    // R9: first-party bits
    fp_dir = 1'b1; fp_act = 1'b1;
    step();
    expect_obs("R9 fp read", M_RD, {6'b0, 16'h0309});
    step();
    wr(8'h08, 16'h0001, 2'b11);
    expect_obs("R9 fp not written", M_RD, {6'b0, 16'h0309});
    step();
    fp_dir = 1'b0;
    step();
    expect_obs("R9 fp dir low", M_RD, {6'b0, 16'h0109});
    step();
    fp_act = 1'b0;
    // R10: repeated reads leave state alone
    step(); step();
    expect_obs("R10 no side effect", M_ALL, pack(0,0,0,1,1,1,16'h0009));
    step();
    // R5: completion
    eng_done = 1'b1;
    step();
    eng_done = 1'b0;
    expect_obs("R5 done", M_ALL, pack(0,0,1,0,1,1,16'h0009));
    step();
    // R7: clear after done, R4 dir writable again
    wr(8'h08, 16'h0000, 2'b01);
    expect_obs("R7 no abort after done", M_ALL, pack(0,0,1,0,0,0,16'h0000));
    step();
    expect_obs("R7 still no abort", M_ALL, pack(0,0,1,0,0,0,16'h0000));
    step();
    // R11 restart; R8 abort with dir=1
    wr(8'h08, 16'h0009, 2'b01);
    expect_obs("R11 fresh after done", M_ALL, pack(0,0,0,1,1,1,16'h0009));
    step();
    wr(8'h08, 16'h0008, 2'b01);
    expect_obs("R6 R8 abort+drop", M_ALL, pack(1,1,0,0,1,0,16'h0008));
    step();
    expect_obs("R6 single pulse", M_ALL, pack(0,0,0,0,1,0,16'h0008));
    step();
    // R4: dir writable after abort
    wr(8'h08, 16'h0000, 2'b01);
    expect_obs("R4 dir after abort", M_ALL, pack(0,0,0,0,0,0,16'h0000));
    step();
    // R11 restart after abort; R8 abort with dir=0
    wr(8'h08, 16'h0001, 2'b01);
    expect_obs("R11 fresh after abort", M_ALL, pack(0,0,0,1,0,1,16'h0001));
    step();
    wr(8'h08, 16'h0000, 2'b01);
    expect_obs("R8 abort no drop", M_ALL, pack(1,0,0,0,0,0,16'h0000));
    step();
    // R7: write 0 while already stopped
    wr(8'h08, 16'h0000, 2'b01);
    expect_obs("R7 idle clear", M_ALL, pack(0,0,0,0,0,0,16'h0000));
    step();
    // R5: done ignored when idle
    eng_done = 1'b1;
    step();
    eng_done = 1'b0;
    expect_obs("R5 idle done ignored", M_ALL, pack(0,0,0,0,0,0,16'h0000));
    step(); step();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #4000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule